// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block combines five reset requests into one synchronous system reset. The requests are an active-low external reset pin, a timeout from a missing-clock monitor, a comparator output, a conversion-start pin and a one-cycle watchdog overflow pulse. While any request is active the system reset output is held high. After the last request goes away, the output stays high for a fixed number of further clock cycles.

Each time the reset asserts, a status register records the request that caused it. Only the bit for that cause reads 1, and it keeps that value until the next reset begins. Software uses the same register as a write port that arms the optional sources: the missing-clock monitor, the comparator and the conversion-start pin. A power-on reset clears every enable and every flag.

The missing-clock monitor runs from a free-running reference clock. It counts reference-clock cycles in which the system clock shows no activity. When the count reaches a set limit, it raises a request that takes effect once the system clock returns. The controller also gives the downstream converter a gated copy of the conversion-start pin, so that a pin used as a reset source cannot also start conversions.

Top module: `reset_hub`

## Requirements
- R1: The system reset output is high while the synchronised external pin is low. It rises no more than three clock edges after the pin falls.
- R2: After the last active request is removed, the system reset stays high for exactly HOLD_CYCLES (default 12) further clock edges. For the external pin, two synchroniser cycles come on top of that.
- R3: Reading the status register returns the cause flags: bit 0 external pin, bit 2 missing clock, bit 3 watchdog, bit 5 comparator, bit 6 conversion pin. At most one bit is set. It is the bit of the request that started the current or most recent reset, and it is captured on the edge where the reset output rises.
- R4: If several requests start a reset on the same edge, only one flag is recorded. The order of precedence is external pin, then missing clock, then comparator, then conversion pin, then watchdog.
- R5: A low comparator output (non-inverting input below the inverting one) causes a reset only while enable bit 5 is set.
- R6: A low conversion-start pin causes a reset only while enable bit 6 is set. The request is level sensitive, so the reset holds for as long as the pin stays low.
- R7: While enable bit 6 is set, the conversion-trigger output is held high (inactive). Otherwise it follows the pin, delayed by two clock cycles.
- R8: A one-cycle watchdog overflow pulse produces a reset exactly HOLD_CYCLES cycles long and sets flag bit 3.
- R9: With enable bit 2 set, a stop of the system clock lasting longer than MCD_LIMIT reference-clock cycles produces a reset after the clock resumes, and flag bit 2 is set. With bit 2 clear, a clock stop causes no reset.
- R10: Power-on reset holds the reset output high and clears all flags and enables. The output then falls HOLD_CYCLES cycles after power-on reset is released.
- R11: A register write changes only enable bits 2, 5 and 6. It never changes the flags that are read back.
- R12: Requests that arrive while the reset is already high do not change the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| refClk | input | 1 | Free-running reference clock for the missing-clock monitor |
| porN | input | 1 | Asynchronous active-low power-on reset |
| extRstN | input | 1 | Active-low external reset pin (asynchronous) |
| cmpOut | input | 1 | Comparator output; low requests a reset when armed (asynchronous) |
| convPinN | input | 1 | Conversion-start pin; low requests a reset when armed (asynchronous) |
| wdtOverflow | input | 1 | Watchdog overflow pulse, synchronous to clk |
| regWrEn | input | 1 | Write strobe for the enable bits |
| regWrData | input | 8 | Write data; bits 2, 5 and 6 are the enables |
| regRdData | output | 8 | Cause flags |
| sysRst | output | 1 | Synchronous active-high system reset |
| convTrigN | output | 1 | Gated, synchronised conversion-start pin for the converter |

## Verification
Some properties are checked on every cycle by the assertions. Any active request must leave the reset high on the next edge, and the reset may only fall after a cycle with no request. The flags must stay frozen while the reset is already high. The flag vector must hold exactly one bit whenever the reset rises. The monitor may only fire while its synchronised enable is set. Other behaviour can only be shown by the bench's scenarios: the exact stretch length, the precedence order between simultaneous sources, the effect of the enables, the gating of the conversion trigger, and the missing-clock reset after a real clock stop.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  localparam int REG_W     = 8;
  localparam int BIT_EXT   = 0;
  localparam int BIT_MCD   = 2;
  localparam int BIT_WDT   = 3;
  localparam int BIT_CMP   = 5;
  localparam int BIT_CONV  = 6;
  localparam int N_ASYNC   = 4;

  typedef struct packed {
    logic loadHold;
    logic capture;
  } rstc_strobe_t;

endpackage

// File: rtl/rstc_clkmon.sv
module rstc_clkmon #(
  parameter int MCD_LIMIT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic porN,
  input  logic clkTog,
  input  logic mcdEnable,
  input  logic mcdAck,
  output logic mcdHit
);
  localparam int CW = $clog2(MCD_LIMIT + 1);

  logic [SYNC_STAGES:0]   togSync;
  logic [SYNC_STAGES-1:0] enSync;
  logic [SYNC_STAGES-1:0] ackSync;
  logic [CW-1:0]          idleCnt;
  logic                   activity;

  assign activity = togSync[SYNC_STAGES] ^ togSync[SYNC_STAGES-1];

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      togSync <= '0;
      enSync  <= '0;
      ackSync <= '0;
    end else begin
      togSync <= {togSync[SYNC_STAGES-1:0], clkTog};
      enSync  <= {enSync[SYNC_STAGES-2:0], mcdEnable};
      ackSync <= {ackSync[SYNC_STAGES-2:0], mcdAck};
    end
  end

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      idleCnt <= '0;
    end else if (activity) begin
      idleCnt <= '0;
    end else if (idleCnt != CW'(MCD_LIMIT)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      mcdHit <= 1'b0;
    end else if (ackSync[SYNC_STAGES-1]) begin
      mcdHit <= 1'b0;
    end else if (enSync[SYNC_STAGES-1] && idleCnt == CW'(MCD_LIMIT)) begin
      mcdHit <= 1'b1;
    end
  end

  // R9: the monitor only fires while its synchronised enable was set
  assert_hit_needs_enable_R9: assert property (@(posedge refClk) disable iff (!porN)
    $rose(mcdHit) |-> $past(enSync[SYNC_STAGES-1]));

endmodule

// File: rtl/rstc_datapath.sv
module rstc_datapath
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               extRstN,
  input  logic               cmpOut,
  input  logic               convPinN,
  input  logic               wdtOverflow,
  input  logic               mcdHit,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  rstc_strobe_t       strobe,
  input  logic               sysRst,
  output logic [REG_W-1:0]   regRdData,
  output logic               convTrigN,
  output logic               mcdEnable,
  output logic               mcdAck,
  output logic               clkTog,
  output logic               reqAny
);
  logic [N_ASYNC-1:0]     asyncIn;
  logic [N_ASYNC-1:0]     syncOut;
  logic                   enCmp;
  logic                   enConv;
  logic                   reqExt, reqMcd, reqCmp, reqConv, reqWdt;
  logic [REG_W-1:0]       causeByte;
  logic [REG_W-1:0]       flags;

  // all inputs idle high: index 3 carries the inverted monitor request
  assign asyncIn = {~mcdHit, convPinN, cmpOut, extRstN};

  for (genvar i = 0; i < N_ASYNC; i++) begin : gSync
    logic [SYNC_STAGES-1:0] stages;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) stages <= '1;
      else       stages <= {stages[SYNC_STAGES-2:0], asyncIn[i]};
    end
    assign syncOut[i] = stages[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) clkTog <= 1'b0;
    else       clkTog <= ~clkTog;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      mcdEnable <= 1'b0;
      enCmp     <= 1'b0;
      enConv    <= 1'b0;
    end else if (regWrEn) begin
      mcdEnable <= regWrData[BIT_MCD];
      enCmp     <= regWrData[BIT_CMP];
      enConv    <= regWrData[BIT_CONV];
    end
  end

  assign reqExt  = ~syncOut[0];
  assign reqCmp  = enCmp & ~syncOut[1];
  assign reqConv = enConv & ~syncOut[2];
  assign reqMcd  = ~syncOut[3];
  assign reqWdt  = wdtOverflow;
  assign reqAny  = reqExt | reqMcd | reqCmp | reqConv | reqWdt;
  assign mcdAck  = reqMcd;

  always_comb begin
    causeByte = '0;
    if (reqExt)       causeByte[BIT_EXT]  = 1'b1;
    else if (reqMcd)  causeByte[BIT_MCD]  = 1'b1;
    else if (reqCmp)  causeByte[BIT_CMP]  = 1'b1;
    else if (reqConv) causeByte[BIT_CONV] = 1'b1;
    else if (reqWdt)  causeByte[BIT_WDT]  = 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               flags <= '0;
    else if (strobe.capture) flags <= causeByte;
  end

  assign regRdData = flags;
  assign convTrigN = enConv ? 1'b1 : syncOut[2];

  // R12: flags frozen while the reset was already high
  assert_flags_frozen_R12: assert property (@(posedge clk) disable iff (!porN)
    $past(sysRst) |-> $stable(flags));

  // R3: a rising reset carries exactly one cause flag
  assert_single_cause_R3: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRst) |-> $countones(flags) == 1);

  // R3: never more than one flag
  assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (!porN)
    $onehot0(flags));

endmodule

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
#(
  parameter int HOLD_CYCLES = 12
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         reqAny,
  output rstc_strobe_t strobe,
  output logic         sysRst
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] holdCnt;

  assign strobe.loadHold = reqAny;
  assign strobe.capture  = reqAny && (holdCnt == '0);
  assign sysRst          = (holdCnt != '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                holdCnt <= CW'(HOLD_CYCLES);
    else if (strobe.loadHold) holdCnt <= CW'(HOLD_CYCLES);
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  // R1: any active request leaves reset high on the next edge
  assert_req_holds_reset_R1: assert property (@(posedge clk) disable iff (!porN)
    reqAny |=> sysRst);

  // R2: reset only falls after a cycle without requests
  assert_release_after_quiet_R2: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRst) |-> !$past(reqAny));

endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import rstc_pkg::*;
#(
  parameter int HOLD_CYCLES = 12,
  parameter int SYNC_STAGES = 2,
  parameter int MCD_LIMIT   = 1024
) (
  input  logic             clk,
  input  logic             refClk,
  input  logic             porN,
  input  logic             extRstN,
  input  logic             cmpOut,
  input  logic             convPinN,
  input  logic             wdtOverflow,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             sysRst,
  output logic             convTrigN
);
  rstc_strobe_t strobe;
  logic reqAny, mcdHit, mcdEnable, mcdAck, clkTog;

  rstc_clkmon #(.MCD_LIMIT(MCD_LIMIT), .SYNC_STAGES(SYNC_STAGES)) uMon (
    .refClk(refClk), .porN(porN), .clkTog(clkTog),
    .mcdEnable(mcdEnable), .mcdAck(mcdAck), .mcdHit(mcdHit)
  );

  rstc_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .porN(porN), .extRstN(extRstN), .cmpOut(cmpOut),
    .convPinN(convPinN), .wdtOverflow(wdtOverflow), .mcdHit(mcdHit),
    .regWrEn(regWrEn), .regWrData(regWrData), .strobe(strobe),
    .sysRst(sysRst), .regRdData(regRdData), .convTrigN(convTrigN),
    .mcdEnable(mcdEnable), .mcdAck(mcdAck), .clkTog(clkTog), .reqAny(reqAny)
  );

  rstc_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk(clk), .porN(porN), .reqAny(reqAny), .strobe(strobe), .sysRst(sysRst)
  );

endmodule

// File: tb/tb_reset_hub.sv
module tb_reset_hub;
  localparam int HOLD = 12;
  localparam int LIM  = 32;

  logic clk = 0, refClk = 0, clkRun = 1;
  logic porN = 1, extRstN = 1, cmpOut = 1, convPinN = 1, wdtOverflow = 0;
  logic regWrEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic sysRst, convTrigN;

  int nChecks = 0, nFail = 0;

  // reference model state
  int mHold = HOLD;
  logic [7:0] mFlags = 0;
  logic mEn5 = 0, mEn6 = 0;
  logic extQ[$], cmpQ[$], convQ[$];
  bit modelOn = 1;

  reset_hub #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2), .MCD_LIMIT(LIM)) dut (
    .clk(clk), .refClk(refClk), .porN(porN), .extRstN(extRstN), .cmpOut(cmpOut),
    .convPinN(convPinN), .wdtOverflow(wdtOverflow), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sysRst(sysRst),
    .convTrigN(convTrigN)
  );

  always #5 refClk = ~refClk;
  always begin
    #4;
    if (clkRun) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelIdle();
    extQ = '{1'b1, 1'b1};
    cmpQ = '{1'b1, 1'b1};
    convQ = '{1'b1, 1'b1};
  endtask

  initial modelIdle();

  always @(posedge clk) begin
    if (modelOn) begin
      if (!porN) begin
        mHold = HOLD; mFlags = 0; mEn5 = 0; mEn6 = 0;
        modelIdle();
      end else begin
        logic rE, rC, rV, rW;
        rE = !extQ[0];
        rC = mEn5 && !cmpQ[0];
        rV = mEn6 && !convQ[0];
        rW = wdtOverflow;
        if ((rE || rC || rV || rW) && mHold == 0)
          mFlags = rE ? 8'h01 : rC ? 8'h20 : rV ? 8'h40 : 8'h08;
        if (rE || rC || rV || rW) mHold = HOLD;
        else if (mHold > 0) mHold = mHold - 1;
        if (regWrEn) begin mEn5 = regWrData[5]; mEn6 = regWrData[6]; end
        extQ.push_back(extRstN);   void'(extQ.pop_front());
        cmpQ.push_back(cmpOut);    void'(cmpQ.pop_front());
        convQ.push_back(convPinN); void'(convQ.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && $time > 6) begin
      check(sysRst == (mHold != 0), "R1 R2 sysRst per-cycle", sysRst, mHold != 0);
      check(regRdData == mFlags, "R3 flags per-cycle", regRdData, mFlags);
      check(convTrigN == (mEn6 ? 1'b1 : convQ[0]), "R7 convTrigN per-cycle",
            convTrigN, mEn6 ? 1'b1 : convQ[0]);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic writeReg(input logic [7:0] v);
    regWrData = v; regWrEn = 1;
    step(1);
    regWrEn = 0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    int cnt;
    bit saw;
    #2 porN = 0;
    step(3);
    check(sysRst == 1, "R10 reset during POR", sysRst, 1);
    check(regRdData == 0, "R10 flags cleared by POR", regRdData, 0);
    porN = 1;
    step(HOLD + 2);
    check(sysRst == 0, "R10 release after hold", sysRst, 0);

    // R1 R2 R3 external pin
    extRstN = 0; step(5);
    check(sysRst == 1, "R1 pin low resets", sysRst, 1);
    check(regRdData == 8'h01, "R3 external flag", regRdData, 8'h01);
    extRstN = 1; step(HOLD);
    check(sysRst == 1, "R2 stretched after pin high", sysRst, 1);
    step(4);
    check(sysRst == 0, "R2 released", sysRst, 0);
    check(regRdData == 8'h01, "R3 flag kept after release", regRdData, 8'h01);

    // R5 comparator disarmed
    cmpOut = 0; step(6);
    check(sysRst == 0, "R5 disarmed comparator ignored", sysRst, 0);
    cmpOut = 1; step(3);

    // R5 armed comparator
    writeReg(8'h60);
    cmpOut = 0; step(5);
    check(sysRst == 1, "R5 armed comparator resets", sysRst, 1);
    check(regRdData == 8'h20, "R5 comparator flag", regRdData, 8'h20);
    cmpOut = 1; step(20);

    // R6 R7 conversion pin armed
    convPinN = 0; step(30);
    check(sysRst == 1, "R6 level sensitive hold", sysRst, 1);
    check(regRdData == 8'h40, "R6 conversion flag", regRdData, 8'h40);
    check(convTrigN == 1, "R7 trigger blocked", convTrigN, 1);
    convPinN = 1; step(20);

    // R6 R7 disarmed
    writeReg(8'h00);
    convPinN = 0; step(4);
    check(convTrigN == 0, "R7 trigger follows pin", convTrigN, 0);
    check(sysRst == 0, "R6 disarmed pin ignored", sysRst, 0);
    convPinN = 1; step(3);

    // R11 write of other bits
    writeReg(8'h9B);
    check(regRdData == 8'h40, "R11 write leaves flags", regRdData, 8'h40);
    cmpOut = 0; convPinN = 0; step(6);
    check(sysRst == 0, "R11 other bits arm nothing", sysRst, 0);
    cmpOut = 1; convPinN = 1; step(3);

    // R8 watchdog pulse
    wdtOverflow = 1; cnt = 0;
    repeat (HOLD + 5) begin
      @(negedge clk);
      if (sysRst) cnt++;
      #1 wdtOverflow = 0;
    end
    check(cnt == HOLD, "R8 watchdog reset length", cnt, HOLD);
    check(regRdData == 8'h08, "R8 watchdog flag", regRdData, 8'h08);

    // R12 request during reset
    extRstN = 0; step(4);
    wdtOverflow = 1; step(1); wdtOverflow = 0;
    extRstN = 1; step(HOLD + 5);
    check(regRdData == 8'h01, "R12 later request ignored", regRdData, 8'h01);

    // R4 precedence
    writeReg(8'h60);
    cmpOut = 0; convPinN = 0; step(5);
    check(regRdData == 8'h20, "R4 comparator over conversion", regRdData, 8'h20);
    cmpOut = 1; convPinN = 1; step(HOLD + 5);
    extRstN = 0; step(2);
    wdtOverflow = 1; step(1); wdtOverflow = 0;
    step(2);
    check(regRdData == 8'h01, "R4 external over watchdog", regRdData, 8'h01);
    extRstN = 1; step(HOLD + 5);

    // R9 missing clock armed
    writeReg(8'h04);
    step(2); #50;
    modelOn = 0;
    clkRun = 0;
    #(LIM * 10 + 200);
    clkRun = 1;
    saw = 0;
    repeat (200) begin
      @(negedge clk);
      if (sysRst) saw = 1;
      if (saw && !sysRst) break;
    end
    check(saw == 1, "R9 clock stop causes reset", saw, 1);
    check(sysRst == 0, "R9 reset released", sysRst, 0);
    check(regRdData == 8'h04, "R9 missing clock flag", regRdData, 8'h04);
    #1;
    mHold = 0; mFlags = 8'h04; modelIdle();
    modelOn = 1;

    // R9 disarmed
    writeReg(8'h00);
    step(2); #50;
    clkRun = 0;
    #(LIM * 10 + 200);
    clkRun = 1;
    step(40);
    check(sysRst == 0, "R9 disarmed no reset", sysRst, 0);
    check(regRdData == 8'h04, "R9 flag unchanged", regRdData, 8'h04);

    // R10 mid-run POR clears enables
    writeReg(8'h60);
    porN = 0; step(2);
    check(regRdData == 0, "R10 POR clears flags", regRdData, 0);
    porN = 1; step(HOLD + 3);
    cmpOut = 0; step(6);
    check(sysRst == 0, "R10 POR cleared enables", sysRst, 0);
    cmpOut = 1; step(3);

    finishRun();
  end
endmodule